// File: doc/BRIEF.md
# Four-Bank Row State Tracker

This block watches the command pins of an SDRAM interface and keeps a shadow copy of the bank state. For each of four banks it records whether a row is open and which row that is. Controllers, schedulers and protocol monitors use it to decide whether a column access can go straight to a bank or needs an activate first. It can also serve as an on-chip protocol checker that flags commands the memory would not accept.

A command counts only when chip-select is low. The strobe pattern is decoded into activate, read, write, precharge, auto refresh, register set and no-operation or burst terminate. Address bit 10 has two jobs. On a column command it requests auto-precharge. On a precharge it selects all banks instead of one. A command that breaks the bank-state rules raises a one-cycle flag and changes nothing else.

Top module: `bank_row_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, every bank becomes idle and every row register becomes zero. After that edge `all_idle` is 1 and `illegal_cmd` is 0.
- R2: When `cs_n` is 1 at a clock edge, no command is taken. Bank state, row registers and `illegal_cmd` (0) show no change after that edge.
- R3: An activate (`cs_n`,`ras_n`,`cas_n`,`we_n` = 0,0,1,1) to an idle bank named by `ba` opens that bank. After the edge, row register `ba` holds `addr[12:0]`.
- R4: A read (0,1,0,1) or write (0,1,0,0) to an open bank with `addr[10]`=0 is legal and leaves every bank state and row register unchanged.
- R5: A read or write to an open bank with `addr[10]`=1 is legal and makes bank `ba` idle after the edge. The other banks and all row registers are unchanged.
- R6: A precharge (0,0,1,0) with `addr[10]`=0 makes only bank `ba` idle. If that bank is already idle, the command is still legal and has no effect.
- R7: A precharge with `addr[10]`=1 makes all four banks idle, whatever `ba` is.
- R8: An activate to a bank that is already open is illegal. The bank stays open and its row register keeps the old row.
- R9: A read or write to an idle bank is illegal and changes no state.
- R10: An auto refresh (0,0,0,1) or a register set (0,0,0,0, with any `ba`) is illegal while any bank is open and then changes no state. With all banks idle, both are legal and change no state.
- R11: `illegal_cmd` is a registered flag. It is 1 for exactly the cycle after the edge that took an illegal command. Back-to-back illegal commands keep it at 1.
- R12: `all_idle` is 1 exactly when no bit of `bank_open` is 1.
- R13: A no-operation (0,1,1,1) or a burst terminate (0,1,1,0) changes no state and is never illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip-select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row address on activate; bit 10 is the auto-precharge or all-bank flag |
| bank_open | output | 4 | Bit i is 1 when bank i has an open row |
| open_row | output | 52 | Row register of bank i at bits [13*i+12 : 13*i] |
| all_idle | output | 1 | 1 when no bank is open |
| illegal_cmd | output | 1 | One-cycle flag for a rejected command |

## Verification
A wrong open flag shows up at once in the cycle after the command edge, on `bank_open` and `all_idle`. It also shows up again later as a missing or spurious `illegal_cmd` when the next column access, activate or refresh goes to that bank. A corrupted row register only shows on `open_row`, so the row value is compared after every command, including rejected activates that must not overwrite it. The directed sequences set up the precharge forms, the auto-precharge forms and the register-set gating from a mix of open and idle banks. This makes a decode slip between bit 10's two roles change either the open flags or the illegal flag within one cycle.

// File: rtl/bank_trk_pkg.sv
// Shared types for the bank row tracker.
// Assumes the usual active-low strobe order {ras_n, cas_n, we_n}.
package bank_trk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6,
        CMD_BST = 3'd7
    } cmd_t;

endpackage

// File: rtl/bank_cmd_decode.sv
// Turns the four command strobes into one command code.
// Assumes the strobes are already synchronous to clk; when chip-select is high
// the result is CMD_NOP.
module bank_cmd_decode
    import bank_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_t cmd
);

    // Map the strobe pattern to a command code.
    always_comb begin
        if (cs_n) begin
            cmd = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/bank_rule_ctrl.sv
// Applies the bank-state rules to one decoded command.
// Produces per-bank open and close requests and a registered illegal flag.
// Assumes bank_open reflects the state before the current edge.
module bank_rule_ctrl
    import bank_trk_pkg::*;
#(
    parameter int BANK_BITS = 2,
    localparam int NB       = 1 << BANK_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cmd_t                 cmd,
    input  logic [BANK_BITS-1:0] ba,
    input  logic                 ap_flag,
    input  logic [NB-1:0]        bank_open,
    output logic [NB-1:0]        open_req,
    output logic [NB-1:0]        close_req,
    output logic                 illegal_q
);

    logic bad;

    // Decide the state change, or rejection, for the current command.
    always_comb begin
        open_req  = '0;
        close_req = '0;
        bad       = 1'b0;
        case (cmd)
            CMD_ACT: begin
                if (bank_open[ba]) bad = 1'b1;
                else               open_req[ba] = 1'b1;
            end
            CMD_RD, CMD_WR: begin
                if (!bank_open[ba]) bad = 1'b1;
                else if (ap_flag)   close_req[ba] = 1'b1;
            end
            CMD_PRE: begin
                if (ap_flag) close_req = '1;
                else         close_req[ba] = 1'b1;
            end
            CMD_REF, CMD_MRS: begin
                if (|bank_open) bad = 1'b1;
            end
            default: ;
        endcase
    end

    // Register the illegal flag so it lasts one cycle per rejected command.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= bad;
    end

endmodule

// File: rtl/bank_slot.sv
// State of one bank: an open flag and the row latched by the last accepted
// activate. The row register keeps its value after the bank closes.
// Assumes open_req and close_req are never both set.
module bank_slot #(
    parameter int ROW_BITS = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                open_req,
    input  logic                close_req,
    input  logic [ROW_BITS-1:0] row_in,
    output logic                is_open,
    output logic [ROW_BITS-1:0] row_q
);

    // Track the open flag and capture the row on an accepted activate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open <= 1'b0;
            row_q   <= '0;
        end else if (open_req) begin
            is_open <= 1'b1;
            row_q   <= row_in;
        end else if (close_req) begin
            is_open <= 1'b0;
        end
    end

endmodule

// File: rtl/bank_row_tracker.sv
// Top: shadows the open or idle state and the open row of every bank
// from the command pins. It covers no timing parameters and no data path.
// Assumes a synchronous command bus sampled on the rising edge of clk.
module bank_row_tracker
    import bank_trk_pkg::*;
#(
    parameter int BANK_BITS = 2,
    parameter int ROW_BITS  = 13,
    parameter int AP_BIT    = 10,
    localparam int NB       = 1 << BANK_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BANK_BITS-1:0]   ba,
    input  logic [ROW_BITS-1:0]    addr,
    output logic [NB-1:0]          bank_open,
    output logic [NB*ROW_BITS-1:0] open_row,
    output logic                   all_idle,
    output logic                   illegal_cmd
);

    cmd_t          cmd;
    logic [NB-1:0] open_req;
    logic [NB-1:0] close_req;

    bank_cmd_decode dec_i (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    bank_rule_ctrl #(.BANK_BITS(BANK_BITS)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .ba        (ba),
        .ap_flag   (addr[AP_BIT]),
        .bank_open (bank_open),
        .open_req  (open_req),
        .close_req (close_req),
        .illegal_q (illegal_cmd)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bank
        bank_slot #(.ROW_BITS(ROW_BITS)) slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_req  (open_req[i]),
            .close_req (close_req[i]),
            .row_in    (addr),
            .is_open   (bank_open[i]),
            .row_q     (open_row[i*ROW_BITS +: ROW_BITS])
        );
    end

    // Summary flag for the register-set and refresh gate.
    always_comb all_idle = ~|bank_open;

endmodule

// File: rtl/bank_row_tracker_chk.sv
// Checker for bank_row_tracker, relating the command pins to the bank-state
// outputs one cycle later. It is attached to the top module by bind.
module bank_row_tracker_chk #(
    parameter int BANK_BITS = 2,
    parameter int ROW_BITS  = 13,
    parameter int AP_BIT    = 10,
    localparam int NB       = 1 << BANK_BITS
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cs_n,
    input logic                   ras_n,
    input logic                   cas_n,
    input logic                   we_n,
    input logic [BANK_BITS-1:0]   ba,
    input logic [ROW_BITS-1:0]    addr,
    input logic [NB-1:0]          bank_open,
    input logic [NB*ROW_BITS-1:0] open_row,
    input logic                   illegal_cmd
);

    logic                 is_act, is_pre, is_ref;
    logic [BANK_BITS-1:0] ba_q;
    logic [ROW_BITS-1:0]  rows [NB];

    always_comb begin
        is_act = !cs_n && !ras_n &&  cas_n &&  we_n;
        is_pre = !cs_n && !ras_n &&  cas_n && !we_n;
        is_ref = !cs_n && !ras_n && !cas_n &&  we_n;
    end

    for (genvar i = 0; i < NB; i++) begin : g_row
        assign rows[i] = open_row[i*ROW_BITS +: ROW_BITS];
    end

    // Remember the bank of the previous command for the row check.
    always_ff @(posedge clk) ba_q <= ba;

    // R2
    cs_high_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(bank_open) && $stable(open_row) && !illegal_cmd));

    // R3
    act_row_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && !bank_open[ba]) |=> (rows[ba_q] == $past(addr)));

    // R7
    pre_all_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && addr[AP_BIT]) |=> (bank_open == '0));

    // R10
    ref_open_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && (bank_open != '0)) |=> illegal_cmd);

    // R8
    illegal_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_cmd |-> ($stable(bank_open) && $stable(open_row)));

endmodule

bind bank_row_tracker bank_row_tracker_chk #(
    .BANK_BITS (BANK_BITS),
    .ROW_BITS  (ROW_BITS),
    .AP_BIT    (AP_BIT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .ba          (ba),
    .addr        (addr),
    .bank_open   (bank_open),
    .open_row    (open_row),
    .illegal_cmd (illegal_cmd)
);

// File: tb/bank_row_tracker_tb_top.sv
// Directed bench for bank_row_tracker. Each scenario task drives commands and
// checks the outputs against an expectation kept from the requirements.
module bank_row_tracker_tb_top;

    localparam int NB = 4;
    localparam int RB = 13;

    // Command codes as {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] C_DESEL = 4'b1111;
    localparam logic [3:0] C_NOP   = 4'b0111;
    localparam logic [3:0] C_ACT   = 4'b0011;
    localparam logic [3:0] C_RD    = 4'b0101;
    localparam logic [3:0] C_WR    = 4'b0100;
    localparam logic [3:0] C_PRE   = 4'b0010;
    localparam logic [3:0] C_REF   = 4'b0001;
    localparam logic [3:0] C_MRS   = 4'b0000;
    localparam logic [3:0] C_BST   = 4'b0110;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cs_n, ras_n, cas_n, we_n;
    logic [1:0]      ba;
    logic [RB-1:0]   addr;
    logic [NB-1:0]   bank_open;
    logic [NB*RB-1:0] open_row;
    logic            all_idle;
    logic            illegal_cmd;

    int checks = 0;
    int fails  = 0;

    logic [NB-1:0] exp_open;
    logic [RB-1:0] exp_row [NB];
    logic          exp_ill;

    always #5 clk = ~clk;

    bank_row_tracker dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .ba          (ba),
        .addr        (addr),
        .bank_open   (bank_open),
        .open_row    (open_row),
        .all_idle    (all_idle),
        .illegal_cmd (illegal_cmd)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Compare every output with the expectation.
    task automatic check_all(input string tag);
        chk({tag, " bank_open"}, 64'(bank_open), 64'(exp_open));
        for (int i = 0; i < NB; i++)
            chk({tag, " open_row"}, 64'(open_row[i*RB +: RB]), 64'(exp_row[i]));
        chk({tag, " all_idle R12"}, 64'(all_idle), 64'(exp_open == '0));
        chk({tag, " illegal_cmd R11"}, 64'(illegal_cmd), 64'(exp_ill));
    endtask

    // Drive one command for one edge, update the expectation, check after the edge.
    task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic [RB-1:0] a,
                         input string tag);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba   = b;
        addr = a;
        exp_ill = 1'b0;
        case (c)
            C_ACT: if (exp_open[b]) exp_ill = 1'b1;
                   else begin exp_open[b] = 1'b1; exp_row[b] = a; end
            C_RD, C_WR: if (!exp_open[b]) exp_ill = 1'b1;
                        else if (a[10]) exp_open[b] = 1'b0;
            C_PRE: if (a[10]) exp_open = '0; else exp_open[b] = 1'b0;
            C_REF, C_MRS: if (exp_open != '0) exp_ill = 1'b1;
            default: ;
        endcase
        @(posedge clk);
        #2;
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        check_all(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        repeat (3) @(posedge clk);
        #2;
        exp_open = '0;
        for (int i = 0; i < NB; i++) exp_row[i] = '0;
        exp_ill = 1'b0;
        check_all(tag);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        do_reset("R1 reset");
    endtask

    task automatic t_activate;
        issue(C_ACT, 2'd0, 13'h1ABC, "R3 act bank0");
        issue(C_ACT, 2'd2, 13'h0123, "R3 act bank2");
        issue(C_ACT, 2'd3, 13'h1FFF, "R3 act bank3 max row");
        chk("R3 bank3 row", 64'(open_row[3*RB +: RB]), 64'h1FFF);
    endtask

    task automatic t_cs_high;
        issue(C_DESEL, 2'd1, 13'h0555, "R2 deselected");
        chk("R2 bank1 closed", 64'(bank_open[1]), 64'd0);
        @(negedge clk);
        cs_n = 1'b1; ras_n = 1'b0; cas_n = 1'b1; we_n = 1'b1; ba = 2'd1;
        @(posedge clk); #2;
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        check_all("R2 act pattern with cs high");
        issue(C_DESEL, 2'd0, 13'h0400, "R2 deselected a10");
    endtask

    task automatic t_col_no_ap;
        issue(C_RD, 2'd0, 13'h0012, "R4 read no ap");
        issue(C_WR, 2'd2, 13'h03FF, "R4 write no ap");
        chk("R4 banks kept", 64'(bank_open), 64'b1101);
    endtask

    task automatic t_col_ap;
        issue(C_RD, 2'd0, 13'h0401, "R5 read ap");
        chk("R5 bank0 closed", 64'(bank_open[0]), 64'd0);
        chk("R5 bank0 row kept", 64'(open_row[RB-1:0]), 64'h1ABC);
        issue(C_WR, 2'd2, 13'h0402, "R5 write ap");
        chk("R5 bank3 still open", 64'(bank_open), 64'b1000);
    endtask

    task automatic t_pre_single;
        issue(C_ACT, 2'd1, 13'h0ABC, "R6 setup act1");
        issue(C_PRE, 2'd3, 13'h0000, "R6 pre bank3");
        chk("R6 only bank1 left", 64'(bank_open), 64'b0010);
        issue(C_PRE, 2'd0, 13'h1BFF, "R6 pre idle bank");
    endtask

    task automatic t_pre_all;
        issue(C_ACT, 2'd0, 13'h0007, "R7 setup act0");
        issue(C_ACT, 2'd2, 13'h0008, "R7 setup act2");
        issue(C_PRE, 2'd3, 13'h0400, "R7 pre all");
        chk("R7 all closed", 64'(bank_open), 64'd0);
    endtask

    task automatic t_act_open;
        issue(C_ACT, 2'd3, 13'h0A5A, "R8 setup act3");
        issue(C_ACT, 2'd3, 13'h15A5, "R8 act to open bank");
        chk("R8 illegal", 64'(illegal_cmd), 64'd1);
        chk("R8 row kept", 64'(open_row[3*RB +: RB]), 64'h0A5A);
    endtask

    task automatic t_col_idle;
        issue(C_RD, 2'd1, 13'h0000, "R9 read idle");
        chk("R9 illegal read", 64'(illegal_cmd), 64'd1);
        issue(C_WR, 2'd0, 13'h0400, "R9 write ap idle");
        chk("R9 illegal write", 64'(illegal_cmd), 64'd1);
    endtask

    task automatic t_ref_mrs;
        issue(C_REF, 2'd0, 13'h0000, "R10 ref with open bank");
        chk("R10 ref illegal", 64'(illegal_cmd), 64'd1);
        issue(C_MRS, 2'd2, 13'h0033, "R10 ext mrs with open bank");
        chk("R10 mrs illegal", 64'(illegal_cmd), 64'd1);
        issue(C_PRE, 2'd3, 13'h0000, "R10 close bank3");
        issue(C_REF, 2'd0, 13'h0000, "R10 ref all idle");
        chk("R10 ref legal", 64'(illegal_cmd), 64'd0);
        issue(C_MRS, 2'd0, 13'h0032, "R10 mrs all idle");
        chk("R10 mrs legal", 64'(illegal_cmd), 64'd0);
    endtask

    task automatic t_pulse;
        issue(C_RD, 2'd2, 13'h0000, "R11 first illegal");
        issue(C_WR, 2'd2, 13'h0000, "R11 second illegal");
        chk("R11 held high", 64'(illegal_cmd), 64'd1);
        issue(C_NOP, 2'd0, 13'h0000, "R11 drop after nop");
        chk("R11 low", 64'(illegal_cmd), 64'd0);
    endtask

    task automatic t_idle_flag;
        issue(C_ACT, 2'd1, 13'h0111, "R12 open one");
        chk("R12 not idle", 64'(all_idle), 64'd0);
        issue(C_WR, 2'd1, 13'h0400, "R12 close by ap");
        chk("R12 idle", 64'(all_idle), 64'd1);
    endtask

    task automatic t_nop_bst;
        issue(C_ACT, 2'd2, 13'h0222, "R13 setup");
        issue(C_BST, 2'd2, 13'h0400, "R13 burst terminate");
        issue(C_NOP, 2'd2, 13'h1FFF, "R13 nop");
        chk("R13 bank2 open", 64'(bank_open), 64'b0100);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        ba = '0;
        addr = '0;
        exp_open = '0;
        for (int i = 0; i < NB; i++) exp_row[i] = '0;
        exp_ill = 1'b0;
        t_reset();
        t_activate();
        t_cs_high();
        t_col_no_ap();
        t_col_ap();
        t_pre_single();
        t_pre_all();
        t_act_open();
        t_col_idle();
        t_ref_mrs();
        t_pulse();
        t_idle_flag();
        t_nop_bst();
        do_reset("R1 reset from busy state");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule